// File: doc/BRIEF.md
# Indexed Display Control Register Port

This block is the host-facing control register file of a display device. The host never addresses a register directly. It first writes a register number to an index port, then reads or writes the selected register through a value port. The bus front end is a plain strobe interface. A port-select bit chooses between the index port and the value port, and each access takes one cycle. A read strobe returns its data with a valid pulse one cycle later.

The register set holds a version word, the display width and height, the pixel depth, a read-only host depth, a read-only capabilities word, a mode enable bit and a configuration-complete bit. Version negotiation works by echo. The register keeps a written version only if the device supports it, so a host can start at its highest version and step down until the readback matches. The pixel depth can be written only when the capabilities word advertises depth emulation, and even then only the values 8 and the host depth are taken. The enable bit and the configuration-complete bit drive outputs to the rest of the device.

Top module: `dcr_port`

## Requirements
- R1: A value-port write updates the register selected by the last index-port write. The index stays selected across any number of accesses. Register numbers: 0 version, 1 mode enable, 2 width, 3 height, 4 pixel depth, 5 host depth, 6 capabilities, 7 configuration complete. `port_sel` = 0 selects the index port and 1 selects the value port.
- R2: A read strobe on the value port gives `rvalid` high for exactly the next cycle, with `rdata` holding the selected register zero-extended to 32 bits.
- R3: A version write of 0, 1 or 2 is stored. Any other value leaves the previously accepted version in place.
- R4: When capability bit 8 (depth emulation) is clear, pixel-depth writes have no effect.
- R5: When capability bit 8 is set, a pixel-depth write is stored only if the value is 8 or the host depth. Other values leave the register unchanged.
- R6: Bit 0 of a mode-enable write sets `disp_en` from the next cycle: 1 selects the extended mode and 0 falls back to legacy mode.
- R7: Bit 0 of a configuration-complete write drives `cfg_done` from the next cycle. A 0 halts command consumption until a 1 is written.
- R8: An index of 8 or above, including any value with bits above bit 3 set, reads as zero and makes value writes do nothing. In particular, such an index does not alias onto a low register.
- R9: After reset every writable register reads zero, `disp_en` and `cfg_done` are low, capabilities reads the `CAPS` parameter and host depth reads the `HOST_BPP` parameter.
- R10: A read strobe on the index port returns zero with `rvalid`.
- R11: Width and height keep only their low 16 bits. Writes to host depth and capabilities have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| port_sel | input | 1 | 0 selects the index port, 1 selects the value port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Pulses one cycle after a read strobe |
| disp_en | output | 1 | Extended display mode enable |
| cfg_done | output | 1 | Command consumption allowed |

## Verification
The hardest case to reach from the ports is the read-only pixel depth. A single instance has a fixed capabilities word, so it can never show the same depth write accepted in one configuration and ignored in the other. The bench therefore drives two instances from the same bus: one with the emulation bit set and one with it clear. It then compares the readback of each after legal and illegal depth values. A second subtle case is an out-of-range index whose low four bits name a real register. The bench writes width through such an index and reads width back to confirm no aliasing.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int IDX_W    = 4;
    localparam int NUM_REGS = 8;
    localparam int DIM_W    = 16;
    localparam int BPP_W    = 8;
    localparam int MAX_VER  = 2;
    localparam int VER_W    = $clog2(MAX_VER + 1);
    localparam int EMU_BIT  = 8;
    localparam int EMU_BPP  = 8;

    typedef enum logic [IDX_W-1:0] {
        RI_VER  = 4'd0,
        RI_EN   = 4'd1,
        RI_WID  = 4'd2,
        RI_HGT  = 4'd3,
        RI_BPP  = 4'd4,
        RI_HBPP = 4'd5,
        RI_CAPS = 4'd6,
        RI_DONE = 4'd7
    } reg_id_e;

    typedef struct packed {
        logic [VER_W-1:0] ver;
        logic             en;
        logic [DIM_W-1:0] wid;
        logic [DIM_W-1:0] hgt;
        logic [BPP_W-1:0] bpp;
        logic             done;
    } regs_t;

    function automatic logic ver_ok(input logic [31:0] v);
        return v <= 32'(MAX_VER);
    endfunction

    function automatic logic bpp_ok(input logic [31:0] v, input int host, input logic emu);
        return emu && ((v == 32'(EMU_BPP)) || (v == 32'(host)));
    endfunction
endpackage

// File: rtl/dcr_index.sv
module dcr_index
    import dcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [31:0]      wdata,
    output logic [IDX_W-1:0] idx,
    output logic             oob
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            oob <= 1'b0;
        end else if (load) begin
            idx <= wdata[IDX_W-1:0];
            oob <= (wdata >= 32'(NUM_REGS));
        end
    end
endmodule

// File: rtl/dcr_bank.sv
module dcr_bank
    import dcr_pkg::*;
#(
    parameter logic [31:0] CAPS     = 32'h0000_0100,
    parameter int          HOST_BPP = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             oob,
    input  logic [31:0]      wdata,
    output regs_t            q
);
    localparam logic EMU = CAPS[EMU_BIT];

    reg_id_e sel;
    assign sel = reg_id_e'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en && !oob) begin
            unique case (sel)
                RI_VER:  if (ver_ok(wdata)) q.ver <= wdata[VER_W-1:0];
                RI_EN:   q.en  <= wdata[0];
                RI_WID:  q.wid <= wdata[DIM_W-1:0];
                RI_HGT:  q.hgt <= wdata[DIM_W-1:0];
                RI_BPP:  if (bpp_ok(wdata, HOST_BPP, EMU)) q.bpp <= wdata[BPP_W-1:0];
                RI_DONE: q.done <= wdata[0];
                default: ;
            endcase
        end
    end

    // R3
    ver_range_chk: assert property (@(posedge clk) disable iff (rst)
        q.ver <= VER_W'(MAX_VER));

    // R5
    bpp_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (q.bpp == '0) || (q.bpp == BPP_W'(EMU_BPP)) || (q.bpp == BPP_W'(HOST_BPP)));

    // R4
    generate
        if (!EMU) begin : g_ro
            bpp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
                $stable(q.bpp));
        end
    endgenerate

    // R7
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !oob && idx == RI_DONE) |=> (q.done == $past(wdata[0])));
endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
    import dcr_pkg::*;
#(
    parameter logic [31:0] CAPS     = 32'h0000_0100,
    parameter int          HOST_BPP = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_stb,
    input  logic             port_sel,
    input  logic [IDX_W-1:0] idx,
    input  logic             oob,
    input  regs_t            q,
    output logic [31:0]      rdata,
    output logic             rvalid
);
    logic [31:0] word;

    always_comb begin
        word = '0;
        if (port_sel && !oob) begin
            unique case (reg_id_e'(idx))
                RI_VER:  word = 32'(q.ver);
                RI_EN:   word = 32'(q.en);
                RI_WID:  word = 32'(q.wid);
                RI_HGT:  word = 32'(q.hgt);
                RI_BPP:  word = 32'(q.bpp);
                RI_HBPP: word = 32'(HOST_BPP);
                RI_CAPS: word = CAPS;
                RI_DONE: word = 32'(q.done);
                default: word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_stb;
            if (rd_stb) rdata <= word;
        end
    end

    // R2
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rvalid);

    // R8
    oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && port_sel && oob) |=> (rdata == '0));
endmodule

// File: rtl/dcr_port.sv
module dcr_port
    import dcr_pkg::*;
#(
    parameter logic [31:0] CAPS     = 32'h0000_0100,
    parameter int          HOST_BPP = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic        port_sel,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rvalid,
    output logic        disp_en,
    output logic        cfg_done
);
    logic [IDX_W-1:0] idx;
    logic             oob;
    regs_t            q;

    dcr_index u_idx (
        .clk   (clk),
        .rst   (rst),
        .load  (wr_stb && !port_sel),
        .wdata (wdata),
        .idx   (idx),
        .oob   (oob)
    );

    dcr_bank #(.CAPS(CAPS), .HOST_BPP(HOST_BPP)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_stb && port_sel),
        .idx   (idx),
        .oob   (oob),
        .wdata (wdata),
        .q     (q)
    );

    dcr_rdmux #(.CAPS(CAPS), .HOST_BPP(HOST_BPP)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (rd_stb),
        .port_sel (port_sel),
        .idx      (idx),
        .oob      (oob),
        .q        (q),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assign disp_en  = q.en;
    assign cfg_done = q.done;

    // R6
    en_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && port_sel && !oob && idx == RI_EN) |=> (disp_en == $past(wdata[0])));
endmodule

// File: tb/sim_dcr_port.sv
`timescale 1ns/1ps
module sim_dcr_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic        port_sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        rvalid0, rvalid1, en0, en1, done0, done1;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dcr_port #(.CAPS(32'h0000_0100), .HOST_BPP(32)) u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata0), .rvalid(rvalid0), .disp_en(en0), .cfg_done(done0));

    dcr_port #(.CAPS(32'h0000_0003), .HOST_BPP(16)) u1 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata1), .rvalid(rvalid1), .disp_en(en1), .cfg_done(done1));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_stb = 1'b1; port_sel = sel; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0; wdata = '0;
    endtask

    task automatic set_reg(input logic [31:0] i, input logic [31:0] d);
        wr(1'b0, i);
        wr(1'b1, d);
    endtask

    task automatic rd(input logic sel, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        rd_stb = 1'b1; port_sel = sel;
        @(negedge clk);
        rd_stb = 1'b0;
        checks++;
        if (!(rvalid0 && rvalid1)) begin
            fails++;
            $display("FAIL R2: rvalid got %b%b expected 11", rvalid0, rvalid1);
        end
        d0 = rdata0; d1 = rdata1;
        @(negedge clk);
        checks++;
        if (rvalid0 || rvalid1) begin
            fails++;
            $display("FAIL R2: rvalid held got %b%b expected 00", rvalid0, rvalid1);
        end
    endtask

    task automatic get_reg(input logic [31:0] i, output logic [31:0] d0, output logic [31:0] d1);
        wr(1'b0, i);
        rd(1'b1, d0, d1);
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        check("R9 disp_en", 32'(en0), 0);
        check("R9 cfg_done", 32'(done0), 0);
        for (int i = 0; i < 8; i++) begin
            get_reg(i, a, b);
            if (i == 5)      begin check("R9 host depth", a, 32); check("R9 host depth u1", b, 16); end
            else if (i == 6) begin check("R9 caps", a, 32'h100); check("R9 caps u1", b, 3); end
            else             check("R9 zero reg", a, 0);
        end
    endtask

    task automatic t_basic_rw;
        logic [31:0] a, b;
        wr(1'b0, 2);
        wr(1'b1, 32'd1024);
        rd(1'b1, a, b);
        check("R1 width", a, 1024);
        rd(1'b1, a, b);
        check("R1 index sticks", a, 1024);
        set_reg(3, 32'h0001_0300);
        get_reg(3, a, b);
        check("R11 height truncated", a, 32'h0300);
        get_reg(2, a, b);
        check("R1 width untouched", a, 1024);
    endtask

    task automatic t_version;
        logic [31:0] a, b;
        set_reg(0, 2);
        get_reg(0, a, b);
        check("R3 version 2", a, 2);
        set_reg(0, 3);
        get_reg(0, a, b);
        check("R3 version 3 rejected", a, 2);
        set_reg(0, 32'h8000_0001);
        get_reg(0, a, b);
        check("R3 large rejected", a, 2);
        set_reg(0, 1);
        get_reg(0, a, b);
        check("R3 version 1", a, 1);
        set_reg(0, 0);
        get_reg(0, a, b);
        check("R3 version 0", a, 0);
    endtask

    task automatic t_depth;
        logic [31:0] a, b;
        set_reg(4, 8);
        get_reg(4, a, b);
        check("R5 depth 8", a, 8);
        check("R4 depth ro", b, 0);
        set_reg(4, 24);
        get_reg(4, a, b);
        check("R5 depth 24 ignored", a, 8);
        set_reg(4, 32);
        get_reg(4, a, b);
        check("R5 host depth", a, 32);
        set_reg(4, 16);
        get_reg(4, a, b);
        check("R5 depth 16 ignored", a, 32);
        check("R4 depth ro host", b, 0);
    endtask

    task automatic t_enable;
        set_reg(1, 1);
        check("R6 enable on", 32'(en0), 1);
        set_reg(1, 32'h2);
        check("R6 enable off", 32'(en0), 0);
    endtask

    task automatic t_done;
        set_reg(7, 1);
        check("R7 done set", 32'(done0), 1);
        set_reg(7, 0);
        check("R7 done clear", 32'(done0), 0);
        set_reg(7, 32'hFFFF_FFFF);
        check("R7 done again", 32'(done0), 1);
    endtask

    task automatic t_oob;
        logic [31:0] a, b;
        get_reg(9, a, b);
        check("R8 index 9 zero", a, 0);
        set_reg(32'h12, 77);
        get_reg(32'h12, a, b);
        check("R8 alias read zero", a, 0);
        get_reg(2, a, b);
        check("R8 no alias write", a, 1024);
        set_reg(32'h17, 0);
        check("R8 no alias done", 32'(done0), 1);
    endtask

    task automatic t_readonly;
        logic [31:0] a, b;
        set_reg(6, 0);
        get_reg(6, a, b);
        check("R11 caps ro", a, 32'h100);
        set_reg(5, 8);
        get_reg(5, a, b);
        check("R11 host depth ro", a, 32);
    endtask

    task automatic t_idx_read;
        logic [31:0] a, b;
        wr(1'b0, 2);
        rd(1'b0, a, b);
        check("R10 index port read", a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic_rw;
        t_version;
        t_depth;
        t_enable;
        t_done;
        t_oob;
        t_readonly;
        t_idx_read;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule